// File: doc/BRIEF.md
# Write Polarity and Supply-Fail Supervisor

This block sits between a tape write-data source and the head current driver. It turns the serial write-data input into a head polarity bit and allows writing only while the active-low write gate is asserted. A mode bit picks between two codings of the same input. In level coding, every change of the input reverses the polarity. In toggle coding, only a falling edge of the input reverses it, and rising edges are ignored.

The block also supervises the supplies. Two low-voltage comparator outputs, one for the 5 V rail and one for the 12 V rail, pass through a persistence filter. A low indication counts as a failure only after it has stayed high for `QUAL_CYCLES` consecutive clocks, which is 1 µs at 24 MHz by default. A qualified 5 V failure pulls the active-low reset output low and forces writing off, whatever the gate says. Each rail failure sets its own sticky flag. A write-unsafe comparator is considered only while writing, and it sets a third sticky flag. A one-cycle acknowledge pulse clears all three flags.

All inputs are taken as synchronous to `clk`. The comparators and the current drivers sit outside this block.

Top module: `wpol_supervisor`

## Requirements
- R1: In the cycle after reset is released with idle inputs, `wr_pol`=0, `wr_active`=0, `sys_rst_n`=1 and all three flags are 0.
- R2: `wr_active` becomes 1 one clock after `wgate_n` is sampled low, provided there is no 5 V failure. It becomes 0 one clock after `wgate_n` is sampled high.
- R3: With `wmode`=0 (toggle coding) and `wr_active`=1, `wr_pol` inverts at the clock that samples a 1-to-0 change of `wdata`. A 0-to-1 change leaves it unchanged.
- R4: With `wmode`=1 (level coding) and `wr_active`=1, `wr_pol` inverts at the clock that samples any change of `wdata`, and it holds while `wdata` is steady.
- R5: While `wr_active`=0, `wr_pol` is driven to 0 at the next clock and stays 0 whatever `wdata` does.
- R6: A rail failure is qualified at the `QUAL_CYCLES`-th consecutive clock that samples its low indication at 1. A shorter run does nothing, and any sampled 0 restarts the count.
- R7: While the 5 V failure is qualified, `sys_rst_n` is 0 and `wr_active` is 0 from the next clock on, regardless of `wgate_n`. Both recover one and two clocks, respectively, after the indication is sampled low.
- R8: `fail5_flag` becomes 1 one clock after the 5 V failure qualifies and stays 1 after the failure ends, until it is acknowledged.
- R9: A qualified 12 V failure sets `fail12_flag` one clock later and leaves `sys_rst_n` and `wr_active` unchanged.
- R10: `unsafe_raw` sets `unsafe_flag` one clock later only when `wr_active`=1. While `wr_active`=0 it is ignored.
- R11: `flag_ack`=1 clears every flag at the next clock. A set condition present in the same cycle wins, and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous active-low reset |
| wgate_n | input | 1 | write gate, low requests writing |
| wdata | input | 1 | write data input |
| wmode | input | 1 | 0 = toggle on falling edge, 1 = level coding |
| lv5_low | input | 1 | 5 V rail low comparator output |
| lv12_low | input | 1 | 12 V rail low comparator output |
| unsafe_raw | input | 1 | write-unsafe comparator output |
| flag_ack | input | 1 | clears sticky flags |
| wr_pol | output | 1 | head write polarity |
| wr_active | output | 1 | writing in progress |
| sys_rst_n | output | 1 | active-low reset out, low on 5 V failure |
| fail5_flag | output | 1 | sticky 5 V failure flag |
| fail12_flag | output | 1 | sticky 12 V failure flag |
| unsafe_flag | output | 1 | sticky write-unsafe flag |

## Verification
The bench builds the block with `QUAL_CYCLES`=5 instead of 24. With the shorter window, a run one clock too short, a run broken and restarted, and a full qualification all fit into a few dozen cycles for each rail. The exact clock at which `sys_rst_n` falls can then be checked, along with the clock before it where it must still be high. The short window also leaves time to cover acknowledges that land during an ongoing failure, and recovery of the write gate once the 5 V indication drops.

// File: rtl/wps_pkg.sv
// Shared definitions for the write polarity and supply supervisor.
package wps_pkg;
    typedef enum logic {
        WM_TOGGLE = 1'b0,
        WM_LEVEL  = 1'b1
    } wmode_e;

    localparam int RAIL_N  = 2;
    localparam int RAIL_5  = 0;
    localparam int RAIL_12 = 1;

    localparam int FLAG_N      = 3;
    localparam int FLAG_F5     = 0;
    localparam int FLAG_F12    = 1;
    localparam int FLAG_UNSAFE = 2;
endpackage

// File: rtl/wps_persist.sv
// Persistence filter: qual rises once ind has been sampled high on CYCLES
// consecutive clocks and stays high while ind stays high.
// Assumes ind is synchronous to clk. A sampled low restarts the count.
module wps_persist #(
    parameter int CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ind,
    output logic qual
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

    logic [CW-1:0] run_q;

    // Count consecutive high samples, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)              run_q <= '0;
        else if (!ind)           run_q <= '0;
        else if (run_q != LIMIT) run_q <= run_q + 1'b1;
    end

    assign qual = (run_q == LIMIT);

    p_run_before_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
        qual |-> $past(ind));
    p_drop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ind |=> !qual);
endmodule

// File: rtl/wps_sticky.sv
// Sticky event flag: set by set, cleared by ack. Set wins over ack in the
// same cycle. Assumes both inputs are synchronous to clk.
module wps_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic flag
);
    logic flag_q;

    // Hold the flag until acknowledged; a new event takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
        else if (ack) flag_q <= 1'b0;
    end

    assign flag = flag_q;

    p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ack) |=> flag);
    p_set_beats_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
endmodule

// File: rtl/wps_write_path.sv
// Write enable and polarity generator. The enable is registered from the
// gate and the 5 V block signal. The polarity inverts on a decoded data
// event and is forced to 0 while the enable is low.
// Assumes wdata, gate_n and mode are synchronous to clk.
module wps_write_path
    import wps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate_n,
    input  logic block,
    input  logic wdata,
    input  logic mode,
    output logic wr_en,
    output logic pol
);
    logic wr_en_q;
    logic prev_q;
    logic pol_q;
    logic evt;

    // Register the write enable from gate and supply block.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_en_q <= 1'b0;
        else        wr_en_q <= !gate_n && !block;
    end

    // Keep last sampled data bit for edge decoding.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= wdata;
    end

    // Decode a polarity event for the selected coding.
    always_comb begin
        if (mode == WM_LEVEL) evt = wdata ^ prev_q;
        else                  evt = prev_q & ~wdata;
    end

    // Invert polarity on an event while writing, else park at 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        pol_q <= 1'b0;
        else if (!wr_en_q) pol_q <= 1'b0;
        else if (evt)      pol_q <= ~pol_q;
    end

    assign wr_en = wr_en_q;
    assign pol   = pol_q;

    p_idle_pol_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !pol);
    p_rise_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == WM_TOGGLE && !(prev_q && !wdata)) |=> $stable(pol));
    p_level_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == WM_LEVEL && (wdata != prev_q)) |=> (pol != $past(pol)));
endmodule

// File: rtl/wpol_supervisor.sv
// Top level: write polarity generation gated by the write gate and the
// 5 V supply state, two rail persistence filters and three sticky flags.
// Assumes every input is synchronous to clk. QUAL_CYCLES is the persistence
// window in clocks.
module wpol_supervisor
    import wps_pkg::*;
#(
    parameter int QUAL_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wgate_n,
    input  logic wdata,
    input  logic wmode,
    input  logic lv5_low,
    input  logic lv12_low,
    input  logic unsafe_raw,
    input  logic flag_ack,
    output logic wr_pol,
    output logic wr_active,
    output logic sys_rst_n,
    output logic fail5_flag,
    output logic fail12_flag,
    output logic unsafe_flag
);
    logic [RAIL_N-1:0] rail_ind;
    logic [RAIL_N-1:0] rail_qual;
    logic [FLAG_N-1:0] flag_set;
    logic [FLAG_N-1:0] flag_q;
    logic              wr_en;

    assign rail_ind[RAIL_5]  = lv5_low;
    assign rail_ind[RAIL_12] = lv12_low;

    // One persistence filter per supply rail.
    for (genvar i = 0; i < RAIL_N; i++) begin : g_rail
        wps_persist #(.CYCLES(QUAL_CYCLES)) u_persist (
            .clk  (clk),
            .rst_n(rst_n),
            .ind  (rail_ind[i]),
            .qual (rail_qual[i])
        );
    end

    wps_write_path u_wpath (
        .clk   (clk),
        .rst_n (rst_n),
        .gate_n(wgate_n),
        .block (rail_qual[RAIL_5]),
        .wdata (wdata),
        .mode  (wmode),
        .wr_en (wr_en),
        .pol   (wr_pol)
    );

    // Flag set sources: both rails and the writing-qualified unsafe input.
    always_comb begin
        flag_set              = '0;
        flag_set[FLAG_F5]     = rail_qual[RAIL_5];
        flag_set[FLAG_F12]    = rail_qual[RAIL_12];
        flag_set[FLAG_UNSAFE] = unsafe_raw && wr_en;
    end

    for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
        wps_sticky u_sticky (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (flag_set[f]),
            .ack  (flag_ack),
            .flag (flag_q[f])
        );
    end

    assign wr_active   = wr_en;
    assign sys_rst_n   = !rail_qual[RAIL_5];
    assign fail5_flag  = flag_q[FLAG_F5];
    assign fail12_flag = flag_q[FLAG_F12];
    assign unsafe_flag = flag_q[FLAG_UNSAFE];

    p_fail5_blocks_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |=> !wr_active);
    p_unsafe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_active && !unsafe_flag) |=> !unsafe_flag);
    p_rail12_no_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lv5_low |=> sys_rst_n);
endmodule

// File: tb/tb_wpol_supervisor.sv
module tb_wpol_supervisor;
    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wgate_n = 1'b1, wdata = 1'b0, wmode = 1'b0;
    logic lv5_low = 1'b0, lv12_low = 1'b0, unsafe_raw = 1'b0, flag_ack = 1'b0;
    logic wr_pol, wr_active, sys_rst_n, fail5_flag, fail12_flag, unsafe_flag;

    wpol_supervisor #(.QUAL_CYCLES(Q)) dut (
        .clk(clk), .rst_n(rst_n), .wgate_n(wgate_n), .wdata(wdata),
        .wmode(wmode), .lv5_low(lv5_low), .lv12_low(lv12_low),
        .unsafe_raw(unsafe_raw), .flag_ack(flag_ack), .wr_pol(wr_pol),
        .wr_active(wr_active), .sys_rst_n(sys_rst_n), .fail5_flag(fail5_flag),
        .fail12_flag(fail12_flag), .unsafe_flag(unsafe_flag)
    );

    always #10 clk = ~clk;

    // Observation bits: 5 pol, 4 active, 3 sys_rst_n, 2 fail5, 1 fail12, 0 unsafe
    localparam logic [5:0] M_POL = 6'b100000, M_ACT = 6'b010000, M_RST = 6'b001000;
    localparam logic [5:0] M_F5 = 6'b000100, M_F12 = 6'b000010, M_US = 6'b000001;

    typedef struct {
        int         cyc;
        string      req;
        logic [5:0] mask;
        logic [5:0] val;
    } item_t;

    item_t sb[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop expectations due this cycle and compare.
    always @(negedge clk) begin
        logic [5:0] obs;
        obs = {wr_pol, wr_active, sys_rst_n, fail5_flag, fail12_flag, unsafe_flag};
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (it.cyc < cyc) begin
                errors++;
                $display("FAIL %s: expectation for cycle %0d missed (now %0d)", it.req, it.cyc, cyc);
            end else if ((obs & it.mask) !== (it.val & it.mask)) begin
                errors++;
                $display("FAIL %s: cycle %0d actual %b expected %b (mask %b)",
                         it.req, cyc, obs & it.mask, it.val & it.mask, it.mask);
            end
        end
    end

    // Driver-side push of an expectation off clocks ahead.
    task automatic expect_at(input int off, input string req,
                             input logic [5:0] mask, input logic [5:0] val);
        item_t it;
        it.cyc = cyc + off; it.req = req; it.mask = mask; it.val = val;
        sb.push_back(it);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst_n = 1'b1;
        expect_at(1, "R1", 6'h3F, M_RST);
        tick(1);

        // Enable writing, toggle coding.
        wgate_n = 1'b0;
        expect_at(1, "R2", M_POL | M_ACT, M_ACT);
        tick(1);
        wdata = 1'b1; expect_at(1, "R3", M_POL, 6'b0);    tick(1);
        wdata = 1'b0; expect_at(1, "R3", M_POL, M_POL);   tick(1);
        wdata = 1'b1; expect_at(1, "R3", M_POL, M_POL);   tick(1);
        wdata = 1'b0; expect_at(1, "R3", M_POL, 6'b0);    tick(1);

        // Level coding.
        wmode = 1'b1;
        wdata = 1'b1; expect_at(1, "R4", M_POL, M_POL);   tick(1);
        wdata = 1'b0; expect_at(1, "R4", M_POL, 6'b0);    tick(1);
        wdata = 1'b1; expect_at(1, "R4", M_POL, M_POL);
        expect_at(2, "R4", M_POL, M_POL);
        tick(2);

        // Close the gate: polarity parks at 0 and ignores data.
        wgate_n = 1'b1;
        expect_at(1, "R2", M_POL | M_ACT, M_POL);
        expect_at(2, "R5", M_POL | M_ACT, 6'b0);
        tick(1);
        wdata = 1'b0; tick(1);
        wdata = 1'b1; expect_at(1, "R5", M_POL, 6'b0); tick(1);
        wdata = 1'b0; expect_at(1, "R5", M_POL, 6'b0); tick(1);

        // Reopen in toggle coding.
        wmode = 1'b0; wgate_n = 1'b0;
        expect_at(2, "R2", M_POL | M_ACT, M_ACT);
        tick(2);
        wdata = 1'b1; tick(1);
        wdata = 1'b0; expect_at(1, "R3", M_POL, M_POL); tick(1);

        // Unsafe while writing, then acknowledge.
        unsafe_raw = 1'b1; expect_at(1, "R10", M_US, M_US); tick(1);
        unsafe_raw = 1'b0; expect_at(1, "R11", M_US, M_US); tick(1);
        flag_ack = 1'b1;   expect_at(1, "R11", M_US, 6'b0); tick(1);
        flag_ack = 1'b0;

        // Unsafe ignored while idle.
        wgate_n = 1'b1; tick(2);
        unsafe_raw = 1'b1;
        expect_at(1, "R10", M_US | M_ACT, 6'b0);
        expect_at(2, "R10", M_US | M_ACT, 6'b0);
        tick(2);
        unsafe_raw = 1'b0;

        // Set wins over simultaneous acknowledge.
        wgate_n = 1'b0; tick(2);
        unsafe_raw = 1'b1; flag_ack = 1'b1;
        expect_at(1, "R11", M_US, M_US); tick(1);
        unsafe_raw = 1'b0;
        expect_at(1, "R11", M_US, 6'b0); tick(1);
        flag_ack = 1'b0;

        // 12 V run one clock short of the window.
        lv12_low = 1'b1; tick(Q - 1);
        lv12_low = 1'b0;
        expect_at(2, "R6", M_F12, 6'b0);
        tick(2);
        // Broken run: restart after a low sample.
        lv12_low = 1'b1; tick(Q - 1);
        lv12_low = 1'b0; tick(1);
        lv12_low = 1'b1; tick(Q - 1);
        lv12_low = 1'b0;
        expect_at(2, "R6", M_F12, 6'b0);
        tick(3);

        // Full 12 V failure.
        lv12_low = 1'b1;
        expect_at(Q, "R6", M_F12, 6'b0);
        expect_at(Q + 1, "R9", M_F12 | M_RST | M_ACT, M_F12 | M_RST | M_ACT);
        tick(Q + 1);
        lv12_low = 1'b0;
        expect_at(2, "R9", M_F12 | M_RST, M_F12 | M_RST);
        tick(2);
        flag_ack = 1'b1; expect_at(1, "R11", M_F12, 6'b0); tick(1);
        flag_ack = 1'b0;

        // Full 5 V failure with the gate held low.
        lv5_low = 1'b1;
        expect_at(Q - 1, "R6", M_RST | M_ACT, M_RST | M_ACT);
        expect_at(Q, "R7", M_RST | M_ACT | M_F5, M_ACT);
        expect_at(Q + 1, "R8", M_RST | M_ACT | M_F5, M_F5);
        tick(Q + 1);
        flag_ack = 1'b1; expect_at(1, "R11", M_F5, M_F5); tick(1);
        flag_ack = 1'b0;
        lv5_low = 1'b0;
        expect_at(1, "R7", M_RST | M_ACT, M_RST);
        expect_at(2, "R7", M_RST | M_ACT | M_F5, M_RST | M_ACT | M_F5);
        tick(3);
        flag_ack = 1'b1; expect_at(1, "R8", M_F5, 6'b0); tick(1);
        flag_ack = 1'b0;
        tick(2);

        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1: %0d expectations left actual pending expected 0", sb.size());
        end
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1: watchdog expired actual running expected finished");
            finish_run();
        end
    end
endmodule